// File: doc/BRIEF.md
# Timer Output Compare Controller

This block holds a 16-bit up-counter that never stops and two output compare channels, A and B, all reached through a byte-wide CPU register port. A prescaler feeds the counter one count-enable pulse at a time. The pulse comes either from one of three internal division taps of the system clock or from rising edges on an external clock pin. When the counter equals a channel's compare value, that channel's output latch is loaded with a level that software has programmed.

Software selects the counter rate with a 2-bit clock-select field. It sets up the channels through a control byte, which holds a register-select bit, two output enables and two output levels. Both 16-bit compare registers sit behind one shared pair of byte addresses, one for the upper byte and one for the lower byte. The register-select bit decides which compare register these addresses reach. A compare register takes a new value as a whole: the upper byte waits in a holding latch and is committed together with the lower byte. While a channel's output enable is low, the pin drive enable for that channel is low, so the surrounding port logic keeps the pin for general-purpose I/O.

Top module: `tmr_ocmp_top`

## Requirements
- R1: After reset the control byte reads 0xE0 and the clock select reads 0x00. Both compare registers read 0xFF at the upper address and 0xFF at the lower address. The counter is 0, and both output latches and both drive enables are 0.
- R2: Control byte fields: bit 4 is the register select, bit 3 the enable for A, bit 2 the enable for B, bit 1 the level for A and bit 0 the level for B. Bits 7..5 ignore writes and always read 1.
- R3: A cycle with standby_i high returns the control byte to 0xE0. The compare registers are left as they were.
- R4: Clock select (address 0, bits 1..0) sets the counter period. Code 00 gives one count every 2 clocks, 01 one every 8 and 10 one every 32.
- R5: With clock select 11, the counter advances once for each rising edge on ext_clk_i, provided each level is held at least two clocks. It does not move while ext_clk_i is steady.
- R6: The counter advances by one per count pulse and wraps from 0xFFFF to 0x0000.
- R7: With select 0, addresses 2 (upper) and 3 (lower) reach compare register A. With select 1 they reach B. A write to one register never changes the other.
- R8: A write to address 2 leaves the readback of the selected compare register unchanged. The next write to address 3 commits {held upper byte, written lower byte} as one 16-bit value.
- R9: When the counter holds a channel's compare value, the count pulse that advances it loads that channel's output latch with its level bit. The new latch value is visible in the same cycle as the incremented count. At any other time the latch holds its value.
- R10: oe_a_o equals control bit 3 and oe_b_o equals control bit 2, starting from the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| standby_i | input | 1 | Standby entry, clears the control byte |
| addr_i | input | 2 | Register address: 0 clock select, 1 control, 2 compare upper, 3 compare lower |
| wr_i | input | 1 | Write strobe for addr_i / wdata_i |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the address of the previous cycle |
| ext_clk_i | input | 1 | External counter clock, asynchronous |
| cnt_o | output | 16 | Counter value |
| ocmp_a_o | output | 1 | Output latch of channel A |
| ocmp_b_o | output | 1 | Output latch of channel B |
| oe_a_o | output | 1 | Pin drive enable for channel A |
| oe_b_o | output | 1 | Pin drive enable for channel B |

## Verification
A corrupt holding latch or a wrong bank select appears at the next read of the compare addresses, one cycle after the address is presented. It also appears as an output latch that changes at the wrong count. A wrong prescaler tap appears at cnt_o within one period, as a spacing between increments other than 2, 8 or 32 clocks. An error in the match path appears at the first count past the programmed value, in the same cycle cnt_o shows that count.

// File: rtl/toc_pkg.sv
package toc_pkg;
  typedef enum logic [1:0] {
    CK_DIV2  = 2'b00,
    CK_DIV8  = 2'b01,
    CK_DIV32 = 2'b10,
    CK_EXT   = 2'b11
  } clk_sel_e;

  localparam logic [1:0] A_CKS    = 2'd0;
  localparam logic [1:0] A_CTRL   = 2'd1;
  localparam logic [1:0] A_OCR_HI = 2'd2;
  localparam logic [1:0] A_OCR_LO = 2'd3;

  localparam int CTRL_W   = 5;
  localparam int CTRL_SEL = 4;
  localparam int CTRL_OEA = 3;
  localparam int CTRL_OEB = 2;
  localparam int CTRL_LVA = 1;
  localparam int CTRL_LVB = 0;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale
  import toc_pkg::*;
#(
  parameter int DIV_W  = 5,
  parameter int SH0    = 1,
  parameter int SH1    = 3,
  parameter int SH2    = 5,
  parameter int SYNC_N = 2
) (
  input  logic     clk,
  input  logic     rst,
  input  clk_sel_e sel_i,
  input  logic     ext_i,
  output logic     tick_o
);
  localparam logic [DIV_W-1:0] M0 = DIV_W'((1 << SH0) - 1);
  localparam logic [DIV_W-1:0] M1 = DIV_W'((1 << SH1) - 1);
  localparam logic [DIV_W-1:0] M2 = DIV_W'((1 << SH2) - 1);

  logic [DIV_W-1:0]  div_q;
  logic [SYNC_N:0]   sync_q;
  logic              ext_rise;
  logic              tick_d;

  always_ff @(posedge clk) begin
    if (rst) div_q <= '0;
    else     div_q <= div_q + DIV_W'(1);
  end

  // synchronizer chain plus one extra stage for edge detection
  always_ff @(posedge clk) begin
    if (rst) sync_q <= '0;
    else     sync_q <= {sync_q[SYNC_N-1:0], ext_i};
  end

  assign ext_rise = sync_q[SYNC_N-1] & ~sync_q[SYNC_N];

  always_comb begin
    case (sel_i)
      CK_DIV2:  tick_d = (div_q & M0) == M0;
      CK_DIV8:  tick_d = (div_q & M1) == M1;
      CK_DIV32: tick_d = (div_q & M2) == M2;
      default:  tick_d = ext_rise;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) tick_o <= 1'b0;
    else     tick_o <= tick_d;
  end

  // R4: with a steady select no two count pulses are adjacent
  a_r4_no_back_to_back: assert property (@(posedge clk) disable iff (rst)
    (tick_o && $stable(sel_i)) |=> !tick_o);
endmodule

// File: rtl/tmr_cmp_bank.sv
module tmr_cmp_bank #(
  parameter int DATA_W = 8,
  parameter int NCH    = 2,
  parameter int CNT_W  = 2 * DATA_W,
  parameter int SEL_W  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_hi_i,
  input  logic                      wr_lo_i,
  input  logic [SEL_W-1:0]          sel_i,
  input  logic [DATA_W-1:0]         wdata_i,
  output logic [NCH-1:0][CNT_W-1:0] ocr_o,
  output logic [DATA_W-1:0]         rd_hi_o,
  output logic [DATA_W-1:0]         rd_lo_o
);
  logic [DATA_W-1:0] hold_q;
  logic [CNT_W-1:0]  ocr_q [NCH];

  always_ff @(posedge clk) begin
    if (rst)          hold_q <= '1;
    else if (wr_hi_i) hold_q <= wdata_i;
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ocr
    always_ff @(posedge clk) begin
      if (rst)
        ocr_q[g] <= '1;
      else if (wr_lo_i && (sel_i == SEL_W'(g)))
        ocr_q[g] <= {hold_q, wdata_i};
    end
    assign ocr_o[g] = ocr_q[g];

    // R8: an upper-byte write never commits
    a_r8_hi_no_commit: assert property (@(posedge clk) disable iff (rst)
      (wr_hi_i && !wr_lo_i) |=> $stable(ocr_q[g]));
    // R7: a lower-byte write to the other bank leaves this one alone
    a_r7_bank_isolation: assert property (@(posedge clk) disable iff (rst)
      (wr_lo_i && (sel_i != SEL_W'(g))) |=> $stable(ocr_q[g]));
  end

  assign rd_hi_o = ocr_q[sel_i][CNT_W-1:DATA_W];
  assign rd_lo_o = ocr_q[sel_i][DATA_W-1:0];
endmodule

// File: rtl/tmr_ocmp_chan.sv
module tmr_ocmp_chan #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] ocr_i,
  input  logic             lvl_i,
  output logic             out_o
);
  logic hit;

  assign hit = (cnt_i == ocr_i);

  always_ff @(posedge clk) begin
    if (rst)                out_o <= 1'b0;
    else if (tick_i && hit) out_o <= lvl_i;
  end

  // R9: the latch moves only on a count pulse at a match, to the level bit
  a_r9_latch_hold: assert property (@(posedge clk) disable iff (rst)
    !(tick_i && (cnt_i == ocr_i)) |=> $stable(out_o));
  a_r9_latch_load: assert property (@(posedge clk) disable iff (rst)
    (tick_i && (cnt_i == ocr_i)) |=> (out_o == $past(lvl_i)));
endmodule

// File: rtl/tmr_ocmp_top.sv
module tmr_ocmp_top
  import toc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              standby_i,
  input  logic [1:0]        addr_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              ext_clk_i,
  output logic [2*DATA_W-1:0] cnt_o,
  output logic              ocmp_a_o,
  output logic              ocmp_b_o,
  output logic              oe_a_o,
  output logic              oe_b_o
);
  localparam int CNT_W = 2 * DATA_W;
  localparam int NCH   = 2;
  localparam int SEL_W = 1;

  logic [CTRL_W-1:0]         ctrl_q;
  clk_sel_e                  cks_q;
  logic                      tick;
  logic [CNT_W-1:0]          cnt_q;
  logic [NCH-1:0][CNT_W-1:0] ocr;
  logic [DATA_W-1:0]         rd_hi, rd_lo, rd_d;
  logic                      wr_hi, wr_lo;
  logic [2:0]                unused_res_bits;

  assign unused_res_bits = wdata_i[7:5];
  assign wr_hi = wr_i && (addr_i == A_OCR_HI);
  assign wr_lo = wr_i && (addr_i == A_OCR_LO);

  always_ff @(posedge clk) begin
    if (rst || standby_i)
      ctrl_q <= '0;
    else if (wr_i && (addr_i == A_CTRL))
      ctrl_q <= wdata_i[CTRL_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)
      cks_q <= CK_DIV2;
    else if (wr_i && (addr_i == A_CKS))
      cks_q <= clk_sel_e'(wdata_i[1:0]);
  end

  tmr_prescale #(.DIV_W(DIV_W)) u_pre (
    .clk    (clk),
    .rst    (rst),
    .sel_i  (cks_q),
    .ext_i  (ext_clk_i),
    .tick_o (tick)
  );

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (tick) cnt_q <= cnt_q + CNT_W'(1);
  end
  assign cnt_o = cnt_q;

  tmr_cmp_bank #(.DATA_W(DATA_W), .NCH(NCH), .CNT_W(CNT_W), .SEL_W(SEL_W)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .wr_hi_i (wr_hi),
    .wr_lo_i (wr_lo),
    .sel_i   (ctrl_q[CTRL_SEL]),
    .wdata_i (wdata_i),
    .ocr_o   (ocr),
    .rd_hi_o (rd_hi),
    .rd_lo_o (rd_lo)
  );

  tmr_ocmp_chan #(.CNT_W(CNT_W)) u_cha (
    .clk (clk), .rst (rst), .tick_i (tick), .cnt_i (cnt_q),
    .ocr_i (ocr[0]), .lvl_i (ctrl_q[CTRL_LVA]), .out_o (ocmp_a_o)
  );

  tmr_ocmp_chan #(.CNT_W(CNT_W)) u_chb (
    .clk (clk), .rst (rst), .tick_i (tick), .cnt_i (cnt_q),
    .ocr_i (ocr[1]), .lvl_i (ctrl_q[CTRL_LVB]), .out_o (ocmp_b_o)
  );

  assign oe_a_o = ctrl_q[CTRL_OEA];
  assign oe_b_o = ctrl_q[CTRL_OEB];

  always_comb begin
    case (addr_i)
      A_CKS:    rd_d = {{(DATA_W-2){1'b0}}, cks_q};
      A_CTRL:   rd_d = {{(DATA_W-CTRL_W){1'b1}}, ctrl_q};
      A_OCR_HI: rd_d = rd_hi;
      default:  rd_d = rd_lo;
    endcase
  end

  always_ff @(posedge clk) rdata_o <= rd_d;

  // R6: one step per pulse, wrapping, and no drift between pulses
  a_r6_step: assert property (@(posedge clk) disable iff (rst)
    tick |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));
  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(cnt_q));
  // R3: standby empties the control byte
  a_r3_standby_clear: assert property (@(posedge clk) disable iff (rst)
    standby_i |=> (ctrl_q == '0));
  // R2: reserved bits of the control byte read as ones
  a_r2_reserved_ones: assert property (@(posedge clk) disable iff (rst)
    ($past(addr_i) == A_CTRL) |-> (rdata_o[7:5] == 3'b111));
endmodule

// File: tb/tmr_ocmp_top_tb_top.sv
module tmr_ocmp_top_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        standby_i = 1'b0;
  logic [1:0]  addr_i = 2'd0;
  logic        wr_i = 1'b0;
  logic [7:0]  wdata_i = 8'd0;
  logic [7:0]  rdata_o;
  logic        ext_clk_i = 1'b0;
  logic [15:0] cnt_o;
  logic        ocmp_a_o, ocmp_b_o, oe_a_o, oe_b_o;

  int unsigned n_chk = 0;
  int unsigned n_bad = 0;
  longint unsigned cyc = 0;
  bit done = 1'b0;

  logic [15:0] m_ocr [2];
  logic [7:0]  m_hold;
  logic [4:0]  m_ctrl;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  tmr_ocmp_top dut_i (
    .clk(clk), .rst(rst), .standby_i(standby_i), .addr_i(addr_i), .wr_i(wr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .ext_clk_i(ext_clk_i), .cnt_o(cnt_o),
    .ocmp_a_o(ocmp_a_o), .ocmp_b_o(ocmp_b_o), .oe_a_o(oe_a_o), .oe_b_o(oe_b_o)
  );

  function automatic logic [7:0] ctrl_view(logic [4:0] c);
    return {3'b111, c};
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(negedge clk);
    wr_i = 1'b0;
    if (a == 2'd1) m_ctrl = d[4:0];
    if (a == 2'd2) m_hold = d;
    if (a == 2'd3) m_ocr[m_ctrl[4]] = {m_hold, d};
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr_i = a; wr_i = 1'b0;
    @(negedge clk);
    d = rdata_o;
  endtask

  task automatic check_bank(string req);
    logic [7:0] h, l;
    rd(2'd2, h);
    rd(2'd3, l);
    chk({h, l} == m_ocr[m_ctrl[4]], req, {h, l}, m_ocr[m_ctrl[4]]);
  endtask

  task automatic period(output longint p);
    logic [15:0] c0;
    longint t0;
    @(negedge clk); c0 = cnt_o;
    while (cnt_o == c0) @(negedge clk);
    c0 = cnt_o;
    while (cnt_o == c0) @(negedge clk);
    c0 = cnt_o; t0 = cyc;
    while (cnt_o == c0) @(negedge clk);
    p = cyc - t0;
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] d, h, l;
    logic [15:0] tgt;
    longint p;
    int unsigned seed;
    seed = $urandom(32'h5EED_0C01);
    m_ocr[0] = 16'hFFFF; m_ocr[1] = 16'hFFFF; m_hold = 8'hFF; m_ctrl = 5'd0;

    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1: state held in reset
    chk(cnt_o == 16'd0, "R1 counter", cnt_o, 0);
    chk({ocmp_a_o, ocmp_b_o, oe_a_o, oe_b_o} == 4'b0, "R1 outputs",
        {ocmp_a_o, ocmp_b_o, oe_a_o, oe_b_o}, 0);
    rst = 1'b0;
    rd(2'd1, d); chk(d == 8'hE0, "R1 ctrl", d, 8'hE0);
    rd(2'd0, d); chk(d == 8'h00, "R1 clock select", d, 0);
    check_bank("R1 bank A");
    wr(2'd1, 8'h10);
    check_bank("R1 bank B");

    // R2: reserved bits and layout
    wr(2'd1, 8'hFF);
    rd(2'd1, d); chk(d == 8'hFF, "R2 all ones", d, 8'hFF);
    wr(2'd1, 8'h00);
    rd(2'd1, d); chk(d == 8'hE0, "R2 reserved stay 1", d, 8'hE0);

    // R8: directed holding-latch check on bank A
    wr(2'd2, 8'h12); wr(2'd3, 8'h34);
    wr(2'd2, 8'hAB);
    rd(2'd2, h); chk(h == 8'h12, "R8 upper not committed", h, 8'h12);
    wr(2'd3, 8'hCD);
    check_bank("R8 commit");
    // R7: writes to B leave A alone
    wr(2'd1, 8'h10); wr(2'd2, 8'h56); wr(2'd3, 8'h78);
    check_bank("R7 bank B");
    wr(2'd1, 8'h00);
    check_bank("R7 bank A kept");

    // random mix of control and compare accesses
    for (int i = 0; i < 40; i++) begin
      int op;
      logic [7:0] v;
      op = $urandom_range(0, 2);
      v = 8'($urandom);
      if (op == 0) begin
        wr(2'd1, v);
        chk(oe_a_o == v[3] && oe_b_o == v[2], "R10 enables",
            {oe_a_o, oe_b_o}, {v[3], v[2]});
        rd(2'd1, d); chk(d == ctrl_view(v[4:0]), "R2 ctrl readback", d, ctrl_view(v[4:0]));
      end else begin
        wr(2'd2, v);
        if (op == 2) wr(2'd3, 8'($urandom));
        check_bank("R7 R8 random bank");
      end
    end

    // R9: channel A match, level 1
    wr(2'd1, 8'h0A);
    @(negedge clk); tgt = cnt_o + 16'd40;
    wr(2'd2, tgt[15:8]); wr(2'd3, tgt[7:0]);
    chk(oe_a_o == 1'b1, "R10 enable A on", oe_a_o, 1);
    while (cnt_o != tgt) @(negedge clk);
    chk(ocmp_a_o == 1'b0, "R9 A before match", ocmp_a_o, 0);
    while (cnt_o == tgt) @(negedge clk);
    chk(ocmp_a_o == 1'b1, "R9 A on match", ocmp_a_o, 1);
    // R9: channel B match, level 1; A holds
    wr(2'd1, 8'h15);
    @(negedge clk); tgt = cnt_o + 16'd40;
    wr(2'd2, tgt[15:8]); wr(2'd3, tgt[7:0]);
    while (cnt_o != tgt) @(negedge clk);
    chk(ocmp_b_o == 1'b0, "R9 B before match", ocmp_b_o, 0);
    while (cnt_o == tgt) @(negedge clk);
    chk(ocmp_b_o == 1'b1, "R9 B on match", ocmp_b_o, 1);
    chk(ocmp_a_o == 1'b1, "R9 A holds", ocmp_a_o, 1);
    // R9: B back to level 0 on a second match
    wr(2'd1, 8'h14);
    @(negedge clk); tgt = cnt_o + 16'd30;
    wr(2'd2, tgt[15:8]); wr(2'd3, tgt[7:0]);
    while (cnt_o != tgt) @(negedge clk);
    chk(ocmp_b_o == 1'b1, "R9 B before clear", ocmp_b_o, 1);
    while (cnt_o == tgt) @(negedge clk);
    chk(ocmp_b_o == 1'b0, "R9 B cleared", ocmp_b_o, 0);

    // R3: standby
    wr(2'd1, 8'h1F);
    @(negedge clk); standby_i = 1'b1;
    @(negedge clk); standby_i = 1'b0;
    m_ctrl = 5'd0;
    rd(2'd1, d); chk(d == 8'hE0, "R3 ctrl cleared", d, 8'hE0);
    check_bank("R3 bank A kept");

    // R4: prescale periods
    wr(2'd0, 8'h01); period(p); chk(p == 8, "R4 div8", p, 8);
    wr(2'd0, 8'h02); period(p); chk(p == 32, "R4 div32", p, 32);
    wr(2'd0, 8'h00); period(p); chk(p == 2, "R4 div2", p, 2);
    rd(2'd0, d); chk(d == 8'h00, "R4 select readback", d, 0);

    // R5: external edges
    wr(2'd0, 8'h03);
    repeat (8) @(negedge clk);
    tgt = cnt_o;
    repeat (20) @(negedge clk);
    chk(cnt_o == tgt, "R5 steady ext", cnt_o, tgt);
    for (int k = 0; k < 5; k++) begin
      ext_clk_i = 1'b1; repeat (4) @(negedge clk);
      ext_clk_i = 1'b0; repeat (4) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    chk(cnt_o == tgt + 16'd5, "R5 five edges", cnt_o, tgt + 16'd5);

    // R6: wrap at div2
    wr(2'd0, 8'h00);
    while (cnt_o != 16'hFFFF) @(negedge clk);
    while (cnt_o == 16'hFFFF) @(negedge clk);
    chk(cnt_o == 16'h0000, "R6 wrap", cnt_o, 0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule